// File: doc/BRIEF.md
# Queue Interrupt Status Controller

This block raises the interrupts for a hardware queue manager that serves 64 queues, split into a lower and an upper half of 32. Every queue supplies its status flags as inputs. Queues in the lower half each carry four flags. Software picks, per queue, which one of those flags (or its complement) counts as that queue's interrupt condition. Queues in the upper half supply one flag, not-nearly-empty, which is always their interrupt condition.

Each half has an enable word, a sticky status word and one interrupt output. A rising edge of an enabled queue's condition sets its status bit. Software clears status bits by writing ones to them. The interrupt output of a half is high while any of its status bits is set and enabled. A flat register bus gives access to the source-select words, the enable and status words, and read-only views of the raw flags.

Register map (4-bit word address): 0-3 source-select words, 4 lower enable, 5 upper enable, 6 lower status, 7 upper status, 8-11 lower flag words, 12 upper not-nearly-empty word. Other addresses read as zero.

Top module: `qirq_ctrl`

## Requirements
- R1: After reset, the source-select words, both enable words and both status words read zero, and both interrupt outputs are low.
- R2: For lower queue q, bits 1:0 of its source code give a flag index f. The condition is input bit `flags_lo[4q+f]`. Changes on the other flags of that queue have no effect on its status bit.
- R3: When bit 2 of a lower queue's source code is 1, its condition is the complement of the selected flag. A falling flag then sets the status, and a rising flag does not.
- R4: A status bit is set only on a 0-to-1 change of the condition while the queue's enable bit is 1. The enables are at address 4 (lower, bit q) and address 5 (upper, bit k).
- R5: Writing a word to address 6 (lower status) or 7 (upper status) clears each bit written as 1. Bits written as 0 keep their value.
- R6: `irq_lo` and `irq_hi` are each the OR of status AND enable over their half. Clearing an enable bit drops the interrupt but keeps the status bit.
- R7: Upper queue 32+k has no source selection. Its status bit k (address 7) is set by a rising `ne_hi[k]` while enabled.
- R8: If a set condition and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Address 8+w reads `flags_lo[32w+31:32w]`, and address 12 reads `ne_hi`.
- R10: Source word w (address w) holds queue 8w+j's 3-bit code in bits 4j+2:4j. Bit 4j+3 is reserved and reads 0.
- R11: A set status bit stays set after its condition falls, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flags_lo | input | 128 | Four flags per lower queue, queue q at bits 4q+3:4q |
| ne_hi | input | 32 | Not-nearly-empty flag of each upper queue |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_lo | output | 1 | Interrupt of the lower half |
| irq_hi | output | 1 | Interrupt of the upper half |

## Verification
One lower queue gets a direct flag selection. The bench toggles an unselected flag of that queue and then the selected one, which shows that only the chosen flag index reaches the status. A second queue uses an inverted selection; driving its flag high and then low shows that only the falling edge counts. An enable is dropped while its status is held, and an edge arrives while disabled, which separates the enable gate on setting from the enable mask on the interrupt output. On the upper half, an edge and a write-one clear land in the same cycle; this tells set priority apart from clear priority, and a clear issued on its own serves as the control.

// File: rtl/qirq_pkg.sv
// Shared constants for the queue interrupt controller.
// Assumes a 4-bit word address space and 4 flags per lower-half queue.
package qirq_pkg;
    localparam int FLAGS_PER_Q = 4;
    localparam int CODE_W      = 3;
    localparam int NIB_W       = 4;
    localparam int AW          = 4;

    localparam logic [AW-1:0] A_SRC0   = 4'd0;
    localparam logic [AW-1:0] A_EN_LO  = 4'd4;
    localparam logic [AW-1:0] A_EN_HI  = 4'd5;
    localparam logic [AW-1:0] A_ST_LO  = 4'd6;
    localparam logic [AW-1:0] A_ST_HI  = 4'd7;
    localparam logic [AW-1:0] A_FLG0   = 4'd8;
    localparam logic [AW-1:0] A_NE_HI  = 4'd12;
endpackage

// File: rtl/qirq_srcsel.sv
// Per-queue source selection for the lower half.
// Holds a 3-bit code per queue, packed one nibble per queue in NWORDS
// words, and derives each queue's interrupt condition from its flags.
// Assumes HALF_Q is a multiple of 4 and words are HALF_Q bits wide.
module qirq_srcsel
    import qirq_pkg::*;
#(
    parameter int HALF_Q = 32,
    localparam int NWORDS = (HALF_Q * NIB_W) / HALF_Q,
    localparam int QPW    = HALF_Q / NIB_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NWORDS-1:0]                 wr_word,
    input  logic [HALF_Q-1:0]                 wdata,
    input  logic [HALF_Q*FLAGS_PER_Q-1:0]     flags,
    output logic [NWORDS-1:0][HALF_Q-1:0]     src_words,
    output logic [HALF_Q-1:0]                 cond
);
    logic [HALF_Q-1:0][CODE_W-1:0] code_q;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        for (genvar j = 0; j < QPW; j++) begin : g_q
            localparam int Q = w * QPW + j;

            // Capture this queue's code when its word is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    code_q[Q] <= '0;
                else if (wr_word[w])
                    code_q[Q] <= wdata[j*NIB_W +: CODE_W];
            end

            // Readback nibble with the reserved top bit forced to zero.
            always_comb begin
                src_words[w][j*NIB_W +: NIB_W] = {1'b0, code_q[Q]};
            end

            // Selected flag, optionally inverted, is the queue's condition.
            always_comb begin
                cond[Q] = flags[Q*FLAGS_PER_Q + int'(code_q[Q][1:0])] ^ code_q[Q][2];
            end
        end
    end

    // R2/R10: a written nibble is captured as that queue's code.
    a_r10_code_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word[0] |=> (code_q[0] == $past(wdata[CODE_W-1:0])));
endmodule

// File: rtl/qirq_half.sv
// Enable, sticky status and interrupt output for one half of the queues.
// A rising condition of an enabled queue sets its status bit. Status
// bits clear on a write of ones, and a same-cycle set wins over a clear.
// Assumes cond is already the per-queue selected condition.
module qirq_half #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond,
    input  logic         en_wr,
    input  logic         st_clr_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] st_q,
    output logic         irq
);
    logic [W-1:0] cond_q;
    logic [W-1:0] rise;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;

    // Previous condition, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond;
    end

    // Edge, set and clear vectors.
    always_comb begin
        rise    = cond & ~cond_q;
        set_vec = rise & en_q;
        clr_vec = st_clr_wr ? wdata : '0;
    end

    // Enable word, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata;
    end

    // Sticky status: clear first, then set on top so that the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_vec) | set_vec;
    end

    // Half interrupt output.
    always_comb begin
        irq = |(st_q & en_q);
    end

    // R4: a bit that was disabled cannot become set.
    a_r4_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~en_q & ~st_q)) |=> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));
    // R5: a bit written with one and not set that cycle is cleared.
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((st_q & $past(clr_vec & ~set_vec)) == '0));
    // R8: an enabled rising edge always leaves the bit set.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((~st_q & $past(set_vec)) == '0));
    // R11: without a clear write, no status bit drops.
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !st_clr_wr |=> (($past(st_q) & ~st_q) == '0));
    // R6: with nothing enabled the interrupt stays low.
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: rtl/qirq_ctrl.sv
// Interrupt status controller for a 64-queue manager.
// Decodes the register bus, instantiates the lower-half source selector
// and one status half per queue half, and muxes read data.
// Assumes single-cycle writes and combinational reads.
module qirq_ctrl
    import qirq_pkg::*;
#(
    parameter int HALF_Q = 32,
    localparam int FLG_W  = HALF_Q * FLAGS_PER_Q,
    localparam int NWORDS = FLG_W / HALF_Q
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLG_W-1:0]  flags_lo,
    input  logic [HALF_Q-1:0] ne_hi,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [HALF_Q-1:0] reg_wdata,
    output logic [HALF_Q-1:0] reg_rdata,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic [NWORDS-1:0]             wr_src;
    logic [NWORDS-1:0][HALF_Q-1:0] src_words;
    logic [HALF_Q-1:0]             cond_lo;
    logic [HALF_Q-1:0]             en_lo, en_hi, st_lo, st_hi;

    // Write strobes for the source-select words.
    for (genvar w = 0; w < NWORDS; w++) begin : g_wdec
        always_comb wr_src[w] = reg_wr && (reg_addr == A_SRC0 + AW'(w));
    end

    qirq_srcsel #(.HALF_Q(HALF_Q)) u_src (
        .clk(clk), .rst_n(rst_n), .wr_word(wr_src), .wdata(reg_wdata),
        .flags(flags_lo), .src_words(src_words), .cond(cond_lo)
    );

    qirq_half #(.W(HALF_Q)) u_lo (
        .clk(clk), .rst_n(rst_n), .cond(cond_lo),
        .en_wr(reg_wr && reg_addr == A_EN_LO),
        .st_clr_wr(reg_wr && reg_addr == A_ST_LO),
        .wdata(reg_wdata), .en_q(en_lo), .st_q(st_lo), .irq(irq_lo)
    );

    qirq_half #(.W(HALF_Q)) u_hi (
        .clk(clk), .rst_n(rst_n), .cond(ne_hi),
        .en_wr(reg_wr && reg_addr == A_EN_HI),
        .st_clr_wr(reg_wr && reg_addr == A_ST_HI),
        .wdata(reg_wdata), .en_q(en_hi), .st_q(st_hi), .irq(irq_hi)
    );

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < A_SRC0 + AW'(NWORDS))
            reg_rdata = src_words[reg_addr[1:0]];
        else if (reg_addr >= A_FLG0 && reg_addr < A_FLG0 + AW'(NWORDS))
            reg_rdata = flags_lo[int'(reg_addr[1:0])*HALF_Q +: HALF_Q];
        else begin
            case (reg_addr)
                A_EN_LO: reg_rdata = en_lo;
                A_EN_HI: reg_rdata = en_hi;
                A_ST_LO: reg_rdata = st_lo;
                A_ST_HI: reg_rdata = st_hi;
                A_NE_HI: reg_rdata = ne_hi;
                default: reg_rdata = '0;
            endcase
        end
    end

    // R7: the upper interrupt can only be high with an upper status bit set.
    a_r7_hi_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (st_hi != '0));
endmodule

// File: tb/sim_qirq_ctrl.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares.
module sim_qirq_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] flags_lo = '0;
    logic [31:0]  ne_hi = '0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq_lo, irq_hi;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    qirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .flags_lo(flags_lo), .ne_hi(ne_hi),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // Monitor: pops one item per cycle, 3 ns after the edge.
    always @(posedge clk) begin
        #3;
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = (it.sel == 0) ? reg_rdata : (it.sel == 1) ? {31'd0, irq_lo} : {31'd0, irq_hi};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // sel: 0 = read data at address a, 1 = irq_lo, 2 = irq_hi
    task automatic expect_v(input int sel, input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.sel = sel; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #5;
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_v(0, 4'd0, 32'h0, "R1 src0 reset");
        expect_v(0, 4'd4, 32'h0, "R1 en_lo reset");
        expect_v(0, 4'd7, 32'h0, "R1 st_hi reset");
        expect_v(1, 4'd0, 32'h0, "R1 irq_lo reset");
        expect_v(2, 4'd0, 32'h0, "R1 irq_hi reset");
        // R10 reserved nibble bits
        wr(4'd3, 32'hFFFF_FFFF);
        expect_v(0, 4'd3, 32'h7777_7777, "R10 reserved bits read 0");
        wr(4'd3, 32'h0);
        // R9 flag readback
        flags_lo[127:96] = 32'hDEAD_BEEF;
        expect_v(0, 4'd11, 32'hDEAD_BEEF, "R9 flag word 3");
        expect_v(0, 4'd8, 32'h0, "R9 flag word 0");
        flags_lo = '0;
        // R2 selection of flag 2 on queue 5
        wr(4'd0, 32'h2 << 20);
        wr(4'd4, 32'h1 << 5);
        tick(); flags_lo[20] = 1'b1;
        expect_v(0, 4'd6, 32'h0, "R2 unselected flag ignored");
        tick(); flags_lo[22] = 1'b1;
        expect_v(0, 4'd6, 32'h20, "R2 selected flag sets status");
        expect_v(1, 4'd0, 32'h1, "R6 irq_lo high");
        // R11 sticky
        tick(); flags_lo[22] = 1'b0;
        expect_v(0, 4'd6, 32'h20, "R11 status held after fall");
        // R5 write-one-to-clear
        wr(4'd6, 32'h0);
        expect_v(0, 4'd6, 32'h20, "R5 zero write keeps bit");
        wr(4'd6, 32'h20);
        expect_v(0, 4'd6, 32'h0, "R5 one write clears");
        expect_v(1, 4'd0, 32'h0, "R5 irq_lo low after clear");
        // R3 inverted flag 1 on queue 9
        wr(4'd1, 32'h5 << 4);
        wr(4'd4, (32'h1 << 5) | (32'h1 << 9));
        tick(); flags_lo[37] = 1'b1;
        expect_v(0, 4'd6, 32'h0, "R3 rising flag ignored when inverted");
        tick(); flags_lo[37] = 1'b0;
        expect_v(0, 4'd6, 32'h200, "R3 falling flag sets when inverted");
        // R6 disable masks irq, keeps status
        wr(4'd4, 32'h1 << 5);
        expect_v(1, 4'd0, 32'h0, "R6 irq_lo masked");
        expect_v(0, 4'd6, 32'h200, "R6 status kept when disabled");
        wr(4'd6, 32'h200);
        // R4 edge while disabled does not set
        tick(); flags_lo[37] = 1'b1;
        tick(); flags_lo[37] = 1'b0;
        expect_v(0, 4'd6, 32'h0, "R4 disabled edge ignored");
        // R7 upper half fixed source
        wr(4'd5, 32'h1 << 8);
        tick(); ne_hi[8] = 1'b1;
        expect_v(0, 4'd7, 32'h100, "R7 upper status set");
        expect_v(2, 4'd0, 32'h1, "R7 irq_hi high");
        tick(); ne_hi[3] = 1'b1;
        expect_v(0, 4'd7, 32'h100, "R7 upper disabled queue ignored");
        expect_v(0, 4'd12, 32'h108, "R9 upper flag word");
        // R8 set wins over same-cycle clear
        tick(); ne_hi[8] = 1'b0;
        @(negedge clk);
        ne_hi[8] = 1'b1; reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = 32'h100;
        @(negedge clk); reg_wr = 1'b0;
        expect_v(0, 4'd7, 32'h100, "R8 set wins over clear");
        wr(4'd7, 32'h100);
        expect_v(0, 4'd7, 32'h0, "R8 control clear alone");
        expect_v(2, 4'd0, 32'h0, "R6 irq_hi low");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule